// File: doc/BRIEF.md
# Password-Gated Watchdog Timer

This block is a watchdog timer driven through one 16-bit control register. A write is accepted only when its upper byte holds a fixed password. A write that carries any other upper byte is treated as an attempt by runaway code: the block raises its reset request at once and leaves the configuration untouched. The odds that a crashed program stores exactly the right byte are small, and a wrong guess makes the system recover rather than switch off the protection.

The low byte of an accepted write configures the block: a hold bit, a choice between two tick sources, a two-bit interval select, a self-clearing counter-clear bit, and a mode bit that turns the watchdog into a plain interval timer. In interval-timer mode an expiry raises a sticky interrupt flag and never resets the system. A build-time option makes the configuration write-once: after the first accepted write, any further write counts as a key violation. A reset-cause output tells an expiry reset apart from a key-violation reset.

Top module: `wdt_keyed_ctrl`

## Requirements
- R1: A write (wr_en high) whose bits 15:8 equal 0x5A is accepted; the fields of bits 7:0 take effect from the next cycle.
- R2: A write whose bits 15:8 differ from 0x5A drives rst_req high in the following cycle, sets rst_cause to 2'b10 and leaves the configuration read back on rdata unchanged.
- R3: While hold (bit 7) is 1 the counter does not advance and no expiry occurs.
- R4: Clock source bit 2 selects tick_a (0) or tick_b (1) as the counted tick; interval select bits 1:0 give 2^15, 2^13, 2^9 or 2^6 counted ticks for codes 0, 1, 2, 3. Expiry happens on the last counted tick of the interval.
- R5: With mode bit 4 set (interval timer), an expiry sets irq, which stays high, never raises rst_req, and the counter wraps to zero and keeps counting.
- R6: With mode bit 4 clear (watchdog), an expiry drives rst_req high for exactly the following cycle and sets rst_cause to 2'b01; the counter restarts from zero.
- R7: An accepted write with bit 3 set zeroes the counter and clears irq; bit 3 always reads back as 0.
- R8: rdata shows 0x00 in bits 15:8, the stored hold, mode, source and interval bits in their write positions, and 0 in bits 6, 5 and 3.
- R9: After reset rdata reads 0x0000 (watchdog mode, longest interval, running), the counter is zero, rst_req and irq are low and rst_cause is 2'b00.
- R10: With WRITE_ONCE set, any write after the first accepted one since reset is a key violation handled as in R2, even with the correct password.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wdata | input | 16 | Write data: password in 15:8, command in 7:0 |
| rdata | output | 16 | Control register read value |
| tick_a | input | 1 | Clock-enable tick of the first source |
| tick_b | input | 1 | Clock-enable tick of the second source |
| rst_req | output | 1 | System reset request, one-cycle pulse |
| irq | output | 1 | Sticky interval-timer interrupt flag |
| rst_cause | output | 2 | Cause of the last reset request: 00 none, 01 expiry, 10 key violation |

## Verification
On every cycle the assertions check that a wrong password is followed by a reset request with the configuration held steady, that a held counter never expires, that timer-mode expiry raises the interrupt without a reset while watchdog-mode expiry always resets with a recorded cause, and the fixed zero bits of the read value. The exact cycle of an expiry for each interval code and tick source, the sticky behaviour of the interrupt across wraps, the default longest interval after reset, and the write-once lock are only shown by the bench scenarios against its cycle model.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned B_HOLD = 7;
  localparam int unsigned B_MODE = 4;
  localparam int unsigned B_CLR  = 3;
  localparam int unsigned B_SRC  = 2;
  localparam logic [7:0]  CFG_KEEP = 8'h97;

  localparam logic [1:0] CAUSE_NONE   = 2'b00;
  localparam logic [1:0] CAUSE_EXPIRE = 2'b01;
  localparam logic [1:0] CAUSE_KEY    = 2'b10;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [7:0] keep_cfg(input logic [7:0] cmd);
    return cmd & CFG_KEEP;
  endfunction
endpackage

// File: rtl/wdt_keyguard.sv
module wdt_keyguard #(
  parameter logic [7:0] KEY        = 8'h5A,
  parameter bit         WRITE_ONCE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wkey,
  output logic       accept,
  output logic       violate
);
  logic locked;
  logic key_match;

  assign key_match = (wkey == KEY);

  generate
    if (WRITE_ONCE) begin : g_lock
      logic lock_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lock_q <= 1'b0;
        else if (accept) lock_q <= 1'b1;
      end
      assign locked = lock_q;
    end else begin : g_open
      assign locked = 1'b0;
    end
  endgenerate

  assign accept  = wr_en & key_match & ~locked;
  assign violate = wr_en & ~(key_match & ~locked);
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned EXP0 = 15,
  parameter int unsigned EXP1 = 13,
  parameter int unsigned EXP2 = 9,
  parameter int unsigned EXP3 = 6,
  localparam int unsigned CW  = wdt_keyed_pkg::max4(EXP0, EXP1, EXP2, EXP3)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int unsigned EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CW-1:0] last_tab [4];
  logic [CW-1:0] cnt_q;

  for (genvar i = 0; i < 4; i++) begin : g_last
    assign last_tab[i] = CW'((64'd1 << EXPS[i]) - 64'd1);
  end

  assign expire = tick & run & (cnt_q >= last_tab[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (expire)      cnt_q <= '0;
    else if (tick && run) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_keyed_ctrl.sv
module wdt_keyed_ctrl #(
  parameter logic [7:0]  KEY        = 8'h5A,
  parameter bit          WRITE_ONCE = 1'b0,
  parameter int unsigned EXP0       = 15,
  parameter int unsigned EXP1       = 13,
  parameter int unsigned EXP2       = 9,
  parameter int unsigned EXP3       = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        tick_a,
  input  logic        tick_b,
  output logic        rst_req,
  output logic        irq,
  output logic [1:0]  rst_cause
);
  import wdt_keyed_pkg::*;

  logic [7:0] cfg_q;
  logic       key_ok;
  logic       key_bad;
  logic       expire_evt;
  logic       clr_evt;
  logic       tick_sel;
  logic       wdog_fire;
  logic       rst_req_q;
  logic       irq_q;
  logic [1:0] cause_q;

  wdt_keyguard #(.KEY(KEY), .WRITE_ONCE(WRITE_ONCE)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wkey   (wdata[15:8]),
    .accept (key_ok),
    .violate(key_bad)
  );

  assign tick_sel = cfg_q[B_SRC] ? tick_b : tick_a;
  assign clr_evt  = key_ok & wdata[B_CLR];

  wdt_tick_counter #(.EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_sel),
    .run   (~cfg_q[B_HOLD]),
    .clr   (clr_evt),
    .sel   (cfg_q[1:0]),
    .expire(expire_evt)
  );

  assign wdog_fire = expire_evt & ~cfg_q[B_MODE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= 8'h00;
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else begin
      rst_req_q <= key_bad | wdog_fire;
      if (key_ok) cfg_q <= keep_cfg(wdata[7:0]);
      if (key_bad)        cause_q <= CAUSE_KEY;
      else if (wdog_fire) cause_q <= CAUSE_EXPIRE;
      if (clr_evt)                          irq_q <= 1'b0;
      else if (expire_evt && cfg_q[B_MODE]) irq_q <= 1'b1;
    end
  end

  assign rdata     = {8'h00, cfg_q};
  assign rst_req   = rst_req_q;
  assign irq       = irq_q;
  assign rst_cause = cause_q;
endmodule

// File: rtl/wdt_keyed_ctrl_chk.sv
module wdt_keyed_ctrl_chk #(
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wkey,
  input logic        wclr,
  input logic [15:0] rdata,
  input logic        rst_req,
  input logic        irq,
  input logic [1:0]  rst_cause,
  input logic        key_ok,
  input logic        key_bad,
  input logic        expire_evt,
  input logic        mode_tmr,
  input logic        hold
);
  AST_BAD_KEY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wkey != KEY) |=> (rst_req && rst_cause == 2'b10)); // R2

  AST_BAD_KEY_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> $stable(rdata)); // R2

  AST_HOLD_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !expire_evt); // R3

  AST_TIMER_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mode_tmr && !key_bad) |=> !rst_req); // R5

  AST_TIMER_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mode_tmr && !(key_ok && wclr)) |=> irq); // R5

  AST_WDOG_EXPIRY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !mode_tmr) |=> (rst_req && rst_cause != 2'b00)); // R6

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_cause != 2'b00)); // R6

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && wclr) |=> !irq); // R7

  AST_READ_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[15:8] == 8'h00 && rdata[6:5] == 2'b00 && !rdata[3])); // R8
endmodule

bind wdt_keyed_ctrl wdt_keyed_ctrl_chk #(.KEY(KEY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wkey      (wdata[15:8]),
  .wclr      (wdata[3]),
  .rdata     (rdata),
  .rst_req   (rst_req),
  .irq       (irq),
  .rst_cause (rst_cause),
  .key_ok    (key_ok),
  .key_bad   (key_bad),
  .expire_evt(expire_evt),
  .mode_tmr  (cfg_q[4]),
  .hold      (cfg_q[7])
);

// File: tb/wdt_keyed_ctrl_tb.sv
module wdt_keyed_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic        rst_req, irq;
  logic [1:0]  rst_cause;

  logic        l_wr = 1'b0;
  logic [15:0] l_wdata = 16'h0;
  logic [15:0] l_rdata;
  logic        l_rst_req, l_irq;
  logic [1:0]  l_cause;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  int ta_mode = 0, tb_mode = 0;   // 0 off, 1 every cycle, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;   // 250 MHz

  wdt_keyed_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .tick_a(tick_a), .tick_b(tick_b), .rst_req(rst_req), .irq(irq), .rst_cause(rst_cause));

  wdt_keyed_ctrl #(.WRITE_ONCE(1'b1)) u_dut_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(l_wr), .wdata(l_wdata), .rdata(l_rdata),
    .tick_a(1'b0), .tick_b(1'b0), .rst_req(l_rst_req), .irq(l_irq), .rst_cause(l_cause));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // tick stimulus
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick_a = (ta_mode == 1) || (ta_mode == 2 && lfsr[0]);
    tick_b = (tb_mode == 1) || (tb_mode == 2 && lfsr[3]);
  end

  // behavioural reference model
  int m_cnt, m_lim, m_hold, m_mode, m_src, m_isel, m_irq, m_rq, m_cause;
  int exps[4] = '{15, 13, 9, 6};
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_mode = 0; m_src = 0; m_isel = 0;
      m_irq = 0; m_rq = 0; m_cause = 0;
    end else begin
      bit tk, ev, good, bad;
      tk = m_src ? tick_b : tick_a;
      m_lim = 1 << exps[m_isel];
      ev = tk && !m_hold && (m_cnt >= m_lim - 1);
      bad = wr_en && (wdata[15:8] != 8'h5A);
      good = wr_en && !bad;
      if (ev) m_cnt = 0;
      else if (tk && !m_hold) m_cnt = m_cnt + 1;
      m_rq = bad || (ev && !m_mode);
      if (bad) m_cause = 2;
      else if (ev && !m_mode) m_cause = 1;
      if (good && wdata[3]) m_irq = 0;
      else if (ev && m_mode) m_irq = 1;
      if (good) begin
        m_hold = wdata[7]; m_mode = wdata[4]; m_src = wdata[2]; m_isel = wdata[1:0];
        if (wdata[3]) m_cnt = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rst_req == m_rq[0], "R2/R6 rst_req vs model", rst_req, m_rq);
      chk(irq == m_irq[0], "R5/R7 irq vs model", irq, m_irq);
      chk(rst_cause == m_cause[1:0], "R6 rst_cause vs model", rst_cause, m_cause);
      chk(rdata == {8'h00, m_hold[0], 2'b00, m_mode[0], 1'b0, m_src[0], m_isel[1:0]},
          "R1/R8 rdata vs model", rdata,
          {8'h00, m_hold[0], 2'b00, m_mode[0], 1'b0, m_src[0], m_isel[1:0]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected under 190000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 16'h0;
  endtask

  task automatic lwr(input logic [15:0] d);
    @(negedge clk); l_wr = 1'b1; l_wdata = d;
    @(negedge clk); l_wr = 1'b0; l_wdata = 16'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int seen;
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    chk(rdata == 16'h0000, "R9 rdata after reset", rdata, 0);
    chk(!rst_req && !irq, "R9 outputs low after reset", {rst_req, irq}, 0);
    chk(rst_cause == 2'b00, "R9 cause after reset", rst_cause, 0);

    // R9 default longest interval: expiry after 2^15 ticks of tick_a
    ta_mode = 1; seen = 0;
    for (int i = 0; i < 32770; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    chk(seen == 1, "R9/R6 one reset at default interval", seen, 1);
    chk(rst_cause == 2'b01, "R6 cause expiry", rst_cause, 1);

    // R5 timer mode, shortest interval, random tick_a
    ta_mode = 2;
    wr(16'h5A1B);
    idle(400);
    chk(irq == 1'b1, "R5 irq sticky after expiries", irq, 1);
    chk(rst_req == 1'b0, "R5 no reset in timer mode", rst_req, 0);

    // R7 clear
    wr(16'h5A1B);
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
    chk(rdata[3] == 1'b0, "R7 clear bit reads 0", rdata, 16'h0013);

    // R4 source select: count tick_b, tick_a running only
    tb_mode = 0;
    wr(16'h5A0F);   // watchdog, tick_b, interval 3, clear
    idle(300);
    chk(rst_req == 1'b0 && rst_cause == 2'b01, "R4 tick_a ignored when tick_b selected",
        {rst_req, rst_cause}, 1);
    tb_mode = 1; idle(100);
    tb_mode = 2; ta_mode = 0; idle(600);

    // R4 interval code 2 on tick_a
    ta_mode = 1; wr(16'h5A0A); idle(1100);

    // R3 hold
    wr(16'h5A8B); idle(300);
    chk(rdata == 16'h0083, "R3/R8 hold readback", rdata, 16'h0083);
    chk(rst_req == 1'b0, "R3 no expiry while held", rst_req, 0);

    // R2 wrong key
    @(negedge clk); wr_en = 1'b1; wdata = 16'h5B10;
    @(negedge clk); wr_en = 1'b0; wdata = 16'h0;
    chk(rst_req == 1'b1, "R2 reset on wrong key", rst_req, 1);
    chk(rst_cause == 2'b10, "R2 cause key", rst_cause, 2);
    chk(rdata == 16'h0083, "R2 config unchanged", rdata, 16'h0083);
    idle(1);
    chk(rst_req == 1'b0, "R2 reset is one pulse", rst_req, 0);
    wr(16'h0000);
    wr(16'h5A03); idle(200);

    // R10 write-once instance
    lwr(16'h5A13);
    chk(l_rdata == 16'h0013 && !l_rst_req, "R10 first write accepted", l_rdata, 16'h0013);
    @(negedge clk); l_wr = 1'b1; l_wdata = 16'h5A03;
    @(negedge clk); l_wr = 1'b0; l_wdata = 16'h0;
    chk(l_rst_req == 1'b1, "R10 second write resets", l_rst_req, 1);
    chk(l_cause == 2'b10, "R10 cause key", l_cause, 2);
    chk(l_rdata == 16'h0013, "R10 config locked", l_rdata, 16'h0013);

    ta_mode = 0; tb_mode = 0;
    idle(5);
    finish_run();
  end
endmodule